// File: doc/BRIEF.md
# Multi-Block Erase Scheduler

This block gathers requests to erase uniform blocks of a flash array and runs the erase once requests stop arriving. The first block-confirm event opens an acceptance window. Each further confirm that arrives while the window is open adds its block and starts the window again. When the window runs out, protected blocks are removed from the selection. The remaining blocks are then erased one at a time, lowest index first. Each block is erased through a request/done handshake with a cycle-count model of the erase array.

While an erase is running, it can be suspended and later resumed. A reset strobe stops the erase and holds the block busy for a short recovery period. Any command other than a confirm that arrives during the window aborts the whole request. If every selected block is protected, the block stays busy for a fixed time and then returns to idle without erasing. The window, busy, suspend, abort, done and error outputs feed a separate status generator. All time limits are counted in clock cycles.

Top module: `erase_sched`

## Requirements
- R1: After rst_n is released, pend_o is 0 and busy_o, win_o, susp_o, erase_req_o, abort_o, done_o and err_o are all 0.
- R2: A confirm (cnf_i high, block index on cnf_blk_i) in idle sets bit cnf_blk_i of pend_o and raises win_o. The window lasts exactly WIN_CYC cycles. erase_req_o rises in the same cycle that win_o falls.
- R3: Each confirm received while win_o is high sets its bit in pend_o and restarts the full WIN_CYC window.
- R4: If other_cmd_i, susp_i, resume_i or reset_i arrives while win_o is high, the next cycle gives a one-cycle abort_o pulse with pend_o cleared, win_o low and busy_o low, and no erase starts.
- R5: When the window closes, every block whose bit is set in prot_mask_i is removed from pend_o.
- R6: If every selected block is protected, busy_o stays high for exactly NOPROT_CYC cycles with erase_req_o low and pend_o zero, and the block then returns to idle.
- R7: Pending blocks are erased one at a time in ascending index. While erase_req_o is high, cur_blk_o names the lowest set bit of pend_o. done_i clears that bit. When no bits remain, done_o pulses for one cycle and busy_o falls.
- R8: susp_i during an erase drops erase_req_o and raises susp_o. While suspended, pend_o holds, and confirms and done_i are ignored. resume_i continues with the same block.
- R9: While erasing, cnf_i and resume_i have no effect on pend_o.
- R10: done_i together with fail_i sets err_o. err_o stays set through later successful erases and is cleared only by reset_i.
- R11: reset_i during an erase or a suspend clears pend_o and holds busy_o high for exactly RST_CYC cycles with confirms ignored. The block then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_mask_i | input | NB | Per-block protection mask |
| cnf_i | input | 1 | Block-erase confirm strobe |
| cnf_blk_i | input | $clog2(NB) | Block index carried by the confirm |
| other_cmd_i | input | 1 | Any other command strobe |
| susp_i | input | 1 | Suspend strobe |
| resume_i | input | 1 | Resume strobe |
| reset_i | input | 1 | Command reset strobe |
| done_i | input | 1 | Erase-done handshake for the current block |
| fail_i | input | 1 | Qualifies done_i as a failed erase |
| pend_o | output | NB | Erase-pending vector |
| cur_blk_o | output | $clog2(NB) | Block being erased |
| erase_req_o | output | 1 | Erase request to the array model |
| win_o | output | 1 | Acceptance window running |
| busy_o | output | 1 | Erase, suspend, protect-hold or reset recovery active |
| susp_o | output | 1 | Erase suspended |
| abort_o | output | 1 | One-cycle pulse when the window is aborted |
| done_o | output | 1 | One-cycle pulse when all pending blocks are erased |
| err_o | output | 1 | Sticky erase-failure flag |

## Verification
The hardest case to reach is a suspend that arrives partway through erasing one block of a multi-block set. The stimulus has to stretch the window with repeated confirms, and it has to let the array model run long enough that the block is neither finished nor still waiting to start. The bench's erase responder counts handshake cycles only while erase_req_o is high. The stimulus waits a few of those cycles, suspends, sends a confirm and holds for a while, then resumes. The scoreboard checks that the interrupted block completes before the next block in ascending order.

// File: rtl/es_pkg.sv
package es_pkg;
  typedef enum logic [2:0] {
    ES_IDLE,
    ES_WIN,
    ES_ERASE,
    ES_SUSP,
    ES_NOPROT,
    ES_RWAIT
  } es_state_e;
endpackage

// File: rtl/es_timer.sv
module es_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         dec,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = ld | (dec & (cnt_q != '0));
    cnt_d  = ld ? ld_val : cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R2: a running count never wraps below zero
  a_r2_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !ld && zero_o) |=> zero_o);
endmodule

// File: rtl/es_lowpick.sv
module es_lowpick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  vec,
  output logic          any_o,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  oh_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx_o = IW'(i);
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_oh
    if (g == 0) begin : g_first
      assign oh_o[g] = vec[g];
    end else begin : g_rest
      assign oh_o[g] = vec[g] & ~(|vec[g-1:0]);
    end
  end

  assign any_o = |vec;
endmodule

// File: rtl/erase_sched.sv
module erase_sched
  import es_pkg::*;
#(
  parameter int NB         = 8,
  parameter int WIN_CYC    = 16,
  parameter int NOPROT_CYC = 12,
  parameter int RST_CYC    = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NB-1:0]         prot_mask_i,
  input  logic                  cnf_i,
  input  logic [$clog2(NB)-1:0] cnf_blk_i,
  input  logic                  other_cmd_i,
  input  logic                  susp_i,
  input  logic                  resume_i,
  input  logic                  reset_i,
  input  logic                  done_i,
  input  logic                  fail_i,
  output logic [NB-1:0]         pend_o,
  output logic [$clog2(NB)-1:0] cur_blk_o,
  output logic                  erase_req_o,
  output logic                  win_o,
  output logic                  busy_o,
  output logic                  susp_o,
  output logic                  abort_o,
  output logic                  done_o,
  output logic                  err_o
);
  localparam int IW   = $clog2(NB);
  localparam int TMAX = (WIN_CYC > NOPROT_CYC) ?
                        ((WIN_CYC > RST_CYC) ? WIN_CYC : RST_CYC) :
                        ((NOPROT_CYC > RST_CYC) ? NOPROT_CYC : RST_CYC);
  localparam int CW   = $clog2(TMAX + 1);

  es_state_e      st_q, st_d;
  logic [NB-1:0]  pend_q, pend_d, blk_oh, cur_oh, keep;
  logic           err_q, err_d, abort_q, abort_d, done_q, done_d;
  logic           tmr_ld, tmr_dec, tmr_zero, pick_any;
  logic [CW-1:0]  tmr_val;

  es_timer #(.W(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .ld(tmr_ld), .ld_val(tmr_val),
    .dec(tmr_dec), .zero_o(tmr_zero)
  );

  es_lowpick #(.N(NB), .IW(IW)) u_pick (
    .vec(pend_q), .any_o(pick_any), .idx_o(cur_blk_o), .oh_o(cur_oh)
  );

  assign blk_oh  = NB'(1) << cnf_blk_i;
  assign keep    = pend_q & ~prot_mask_i;
  assign tmr_dec = (st_q == ES_WIN) || (st_q == ES_NOPROT) || (st_q == ES_RWAIT);

  always_comb begin
    st_d    = st_q;
    pend_d  = pend_q;
    err_d   = err_q & ~reset_i;
    abort_d = 1'b0;
    done_d  = 1'b0;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    unique case (st_q)
      ES_IDLE: if (cnf_i) begin
        pend_d  = blk_oh;
        tmr_ld  = 1'b1;
        tmr_val = CW'(WIN_CYC - 1);
        st_d    = ES_WIN;
      end
      ES_WIN: begin
        if (reset_i || other_cmd_i || susp_i || resume_i) begin
          pend_d  = '0;
          abort_d = 1'b1;
          st_d    = ES_IDLE;
        end else if (cnf_i) begin
          pend_d  = pend_q | blk_oh;
          tmr_ld  = 1'b1;
          tmr_val = CW'(WIN_CYC - 1);
        end else if (tmr_zero) begin
          pend_d = keep;
          if (keep == '0) begin
            tmr_ld  = 1'b1;
            tmr_val = CW'(NOPROT_CYC - 1);
            st_d    = ES_NOPROT;
          end else begin
            st_d = ES_ERASE;
          end
        end
      end
      ES_ERASE, ES_SUSP: begin
        if (reset_i) begin
          pend_d  = '0;
          tmr_ld  = 1'b1;
          tmr_val = CW'(RST_CYC - 1);
          st_d    = ES_RWAIT;
        end else if (st_q == ES_SUSP) begin
          if (resume_i) st_d = ES_ERASE;
        end else if (done_i) begin
          pend_d = pend_q & ~cur_oh;
          if (fail_i) err_d = 1'b1;
          if (pend_d == '0) begin
            done_d = 1'b1;
            st_d   = ES_IDLE;
          end else if (susp_i) begin
            st_d = ES_SUSP;
          end
        end else if (susp_i) begin
          st_d = ES_SUSP;
        end
      end
      ES_NOPROT, ES_RWAIT: if (tmr_zero) st_d = ES_IDLE;
      default: st_d = ES_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ES_IDLE;
      pend_q  <= '0;
      err_q   <= 1'b0;
      abort_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      pend_q  <= pend_d;
      err_q   <= err_d;
      abort_q <= abort_d;
      done_q  <= done_d;
    end
  end

  assign pend_o      = pend_q;
  assign erase_req_o = (st_q == ES_ERASE);
  assign win_o       = (st_q == ES_WIN);
  assign susp_o      = (st_q == ES_SUSP);
  assign busy_o      = (st_q == ES_ERASE) || (st_q == ES_SUSP) ||
                       (st_q == ES_NOPROT) || (st_q == ES_RWAIT);
  assign abort_o     = abort_q;
  assign done_o      = done_q;
  assign err_o       = err_q;

  a_r7_req_has_block: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req_o |-> (pick_any && pend_o[cur_blk_o]));
  a_r2_win_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    win_o |-> !erase_req_o);
  a_r4_abort_clean: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (pend_o == '0 && !busy_o && !win_o));
  a_r8_susp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_o && !reset_i) |=> $stable(pend_o));
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !reset_i) |=> err_o);
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && pend_o == '0));
  a_r6_noprot_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !erase_req_o && !susp_o) |-> (pend_o == '0));
endmodule

// File: tb/tb_erase_sched.sv
module tb_erase_sched;
  localparam int NB = 8, W = 16, NP = 12, RC = 5, DUR = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NB-1:0] prot = '0;
  logic cnf = 0, other = 0, susp = 0, resume = 0, rstc = 0, done_i = 0, fail_i = 0;
  logic [2:0] blk = '0;
  logic [NB-1:0] pend;
  logic [2:0] cur;
  logic req, win, busy, suspo, abort, done, err;

  int checks = 0, errors = 0, rcnt = 0, fail_blk = -1;
  bit resp_en = 0, finished = 0;
  int exp_q[$];

  always #5 clk = ~clk;

  erase_sched dut (
    .clk(clk), .rst_n(rst_n), .prot_mask_i(prot), .cnf_i(cnf), .cnf_blk_i(blk),
    .other_cmd_i(other), .susp_i(susp), .resume_i(resume), .reset_i(rstc),
    .done_i(done_i), .fail_i(fail_i), .pend_o(pend), .cur_blk_o(cur),
    .erase_req_o(req), .win_o(win), .busy_o(busy), .susp_o(suspo),
    .abort_o(abort), .done_o(done), .err_o(err)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // erase responder and scoreboard monitor
  always @(negedge clk) begin
    done_i = 0; fail_i = 0;
    if (!resp_en) rcnt = 0;
    else if (req) begin
      rcnt++;
      if (rcnt == DUR) begin
        done_i = 1;
        fail_i = (int'(cur) == fail_blk);
        rcnt = 0;
        if (exp_q.size() == 0) chk("R7 unexpected erase", cur, 32'hff);
        else chk("R7 erase order", cur, exp_q.pop_front());
      end
    end
  end

  task automatic confirm(int b);
    cnf = 1; blk = 3'(b);
    @(negedge clk);
    cnf = 0;
  endtask

  task automatic pulse(ref logic s);
    s = 1;
    @(negedge clk);
    s = 0;
  endtask

  task automatic wait_done(string tag);
    for (int i = 0; i < 600; i++) begin
      if (done) begin chk(tag, 1, 1); return; end
      @(negedge clk);
    end
    chk(tag, 0, 1);
  endtask

  task automatic wait_req();
    for (int i = 0; i < 100; i++) begin
      if (req) return;
      @(negedge clk);
    end
    chk("R7 erase request", 0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset outputs", {pend, req, win, busy, suspo, abort, done, err}, '0);

    // R2: single block, exact window length
    resp_en = 1;
    exp_q.push_back(3);
    confirm(3);
    chk("R2 pend after confirm", pend, 8'h08);
    repeat (W - 1) @(negedge clk);
    chk("R2 window still open", {win, req}, 2'b10);
    @(negedge clk);
    chk("R2 erase starts as window closes", {win, req, busy}, 3'b011);
    wait_done("R7 single done");
    @(negedge clk);
    chk("R7 idle after done", {pend, busy}, '0);

    // R3: restart of window, ascending order
    exp_q.push_back(1); exp_q.push_back(5); exp_q.push_back(6);
    confirm(5);
    repeat (2) @(negedge clk);
    confirm(1);
    repeat (W - 3) @(negedge clk);
    confirm(6);
    chk("R3 blocks collected", pend, 8'h62);
    repeat (W - 1) @(negedge clk);
    chk("R3 window restarted", win, 1);
    wait_done("R7 multi done");
    chk("R7 scoreboard empty", exp_q.size(), 0);

    // R5: protected block dropped
    prot = 8'h20;
    exp_q.push_back(2);
    confirm(5); confirm(2);
    repeat (W) @(negedge clk);
    chk("R5 protected removed", pend, 8'h04);
    wait_done("R5 done");

    // R6: all selected protected
    confirm(5);
    repeat (W) @(negedge clk);
    chk("R6 busy no request", {busy, req, pend}, {2'b10, 8'h00});
    repeat (NP - 1) @(negedge clk);
    chk("R6 still busy", busy, 1);
    @(negedge clk);
    chk("R6 back to idle", busy, 0);
    prot = '0;

    // R4: abort by other command
    confirm(4);
    pulse(other);
    chk("R4 abort pulse", {abort, win, busy, pend}, {3'b100, 8'h00});
    repeat (W + 2) @(negedge clk);
    chk("R4 no erase after abort", {req, busy}, 2'b00);
    confirm(4);
    pulse(susp);
    chk("R4 suspend in window aborts", {abort, win}, 2'b10);

    // R8/R9: suspend and resume mid-block
    exp_q.push_back(0); exp_q.push_back(7);
    confirm(0); confirm(7);
    wait_req();
    repeat (2) @(negedge clk);
    pulse(susp);
    chk("R8 suspended", {suspo, req, pend}, {2'b10, 8'h81});
    confirm(3);
    repeat (20) @(negedge clk);
    chk("R8 pend held in suspend", pend, 8'h81);
    pulse(resume);
    chk("R8 resumed same block", {suspo, req, cur}, {2'b01, 3'd0});
    confirm(4);
    pulse(resume);
    chk("R9 confirm ignored while erasing", pend[4], 0);
    wait_done("R8 done after resume");

    // R10: failure flag
    fail_blk = 2;
    exp_q.push_back(2);
    confirm(2);
    wait_done("R10 done");
    chk("R10 err set", err, 1);
    fail_blk = -1;
    exp_q.push_back(4);
    confirm(4);
    wait_done("R10 second done");
    chk("R10 err sticky", err, 1);
    pulse(rstc);
    chk("R10 err cleared by reset", {err, busy}, 2'b00);

    // R11: reset during erase
    resp_en = 0;
    confirm(1);
    wait_req();
    pulse(rstc);
    chk("R11 reset clears", {pend, busy, req}, {8'h00, 2'b10});
    confirm(3);
    chk("R11 confirm ignored", win, 0);
    repeat (RC - 2) @(negedge clk);
    chk("R11 recovery busy", busy, 1);
    @(negedge clk);
    chk("R11 recovery ends", busy, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule